// File: doc/BRIEF.md
# Configurable GPIO Expander Register Core

This block holds the control and status registers of a general-purpose I/O expander with either one or two 8-bit ports. The port count is set by the `NUM_PORTS` parameter (1 or 2). Each port has four byte-wide registers:

- a read-only pin sample;
- an output level byte;
- a read-inversion mask;
- a direction byte.

A host reaches the registers through a plain byte interface. The host presents an address, then asserts a write strobe with a data byte or a read strobe. The registered read byte appears after the clock edge that samples the read strobe.

On the pin side the core drives an output enable and an output level for every pin. It takes in the raw pin levels through a two-stage synchronizer. The serial bus that normally carries the host accesses, and the pad electrical behaviour, sit outside this block.

There is no sequencing state machine. Every access completes in the cycle its strobe is sampled. The only storage is the three writable registers per port, the synchronizer stages and the read-data register.

Top module: `gpx_core`

## Requirements
- R1: After reset, for every port: the output byte reads 0xFF, the inversion mask reads 0x00 and the direction byte reads 0xFF. All output enables are low, all pin outputs are low and the read data is 0x00.
- R2: With one port, the address map is: 0 is the pin sample, 1 the output byte, 2 the inversion mask and 3 the direction byte.
- R3: With two ports, address bit 0 selects the port and bits 2:1 select the register kind. The map is: 0/1 pin sample, 2/3 output byte, 4/5 inversion mask, 6/7 direction byte, with the even address for port 0 (pins 7:0) and the odd address for port 1 (pins 15:8).
- R4: A direction bit of 1 makes its pin an input, with the output enable low. A 0 makes it an output, with the output enable high. The enables follow a direction write from the next clock edge.
- R5: A pin configured as an output drives the stored output bit. A pin configured as an input drives 0, whatever its output bit holds. The stored output bit is kept, and appears on the pin once the pin is turned into an output.
- R6: The pin-sample read returns the synchronized pin level, inverted where both the inversion bit and the direction bit are 1. Pins configured as outputs read back their raw level even when their inversion bit is set.
- R7: A write to a pin-sample address changes no register and no pin output.
- R8: A read of an address outside the map returns 0x00. A write to such an address changes nothing.
- R9: Consider a pin level captured at clock edge n. A read strobed at edge n+1 still returns the old level. A read strobed at edge n+2 returns the new level.
- R10: The read data changes only at a clock edge that samples the read strobe, and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| pin_in | input | 8*NUM_PORTS | Raw pin levels |
| pin_out | output | 8*NUM_PORTS | Pin output levels |
| pin_oe | output | 8*NUM_PORTS | Pin output enables, high drives the pin |

## Verification
The pin pattern 0xA5 is read back under three settings:

- plain, as an input;
- with a low-nibble inversion mask, which separates inverted input bits from untouched ones;
- after the low nibble is switched to outputs, which shows whether the inversion wrongly reaches output pins.

The output bytes 0x3C, 0x12 and 0x34 are chosen against mixed direction bytes. They separate masked bits from driven bits, and show whether stored levels are kept.

The dual-port instance uses different patterns on the two port halves, 0x5A and 0xC3. It also uses an inversion on one port only, so a swapped port bit or a wrong kind stride returns the other byte.

Writes to the pin-sample address and to addresses just past each map use values that would visibly alter the direction or output byte if the address were aliased. A pin step timed against the read strobe separates the two-stage synchronizer from one of the wrong depth.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        KIND_PIN = 2'd0,
        KIND_OUT = 2'd1,
        KIND_INV = 2'd2,
        KIND_DIR = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic      port;
    } access_s;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;
endmodule

// File: rtl/gpx_addr_dec.sv
module gpx_addr_dec
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 1,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output access_s           acc
);
    localparam int MAP_SIZE = 4 * NUM_PORTS;

    generate
        if (NUM_PORTS == 2) begin : g_dual
            always_comb begin
                acc.hit  = (int'(addr) < MAP_SIZE);
                acc.kind = reg_kind_e'(addr[2:1]);
                acc.port = addr[0];
            end
        end else begin : g_single
            always_comb begin
                acc.hit  = (int'(addr) < MAP_SIZE);
                acc.kind = reg_kind_e'(addr[1:0]);
                acc.port = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/gpx_port_regs.sv
module gpx_port_regs
    import gpx_pkg::*;
#(
    parameter int WIDTH = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  reg_kind_e        kind,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] view_pin,
    output logic [WIDTH-1:0] view_out,
    output logic [WIDTH-1:0] view_inv,
    output logic [WIDTH-1:0] view_dir,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out
);
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] inv_q;
    logic [WIDTH-1:0] dir_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '1;
            inv_q <= '0;
            dir_q <= '1;
        end else if (wr_sel) begin
            unique case (kind)
                KIND_OUT: out_q <= wr_data;
                KIND_INV: inv_q <= wr_data;
                KIND_DIR: dir_q <= wr_data;
                KIND_PIN: ;
            endcase
        end
    end

    always_comb begin
        view_pin = pin_sync ^ (inv_q & dir_q);
        view_out = out_q;
        view_inv = inv_q;
        view_dir = dir_q;
        pin_oe   = ~dir_q;
        pin_out  = out_q & ~dir_q;
    end

    // R7
    pin_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && kind == KIND_PIN) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

    // R4
    dir_to_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && kind == KIND_DIR) |=> (pin_oe == ~$past(wr_data)));
endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int NUM_PORTS = 1,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic                        rd_en,
    output logic [BYTE_W-1:0]           rd_data,
    input  logic [BYTE_W*NUM_PORTS-1:0] pin_in,
    output logic [BYTE_W*NUM_PORTS-1:0] pin_out,
    output logic [BYTE_W*NUM_PORTS-1:0] pin_oe
);
    localparam int PIN_W = BYTE_W * NUM_PORTS;

    access_s          acc;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] sel_view;
    logic [BYTE_W-1:0] rd_next;
    logic [BYTE_W-1:0] rd_q;

    gpx_addr_dec #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .acc  (acc)
    );

    gpx_sync #(.WIDTH(PIN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [BYTE_W-1:0] v_pin, v_out, v_inv, v_dir;
        logic              wsel;

        assign wsel = wr_en && acc.hit && (int'(acc.port) == p);

        gpx_port_regs #(.WIDTH(BYTE_W)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wsel),
            .kind     (acc.kind),
            .wr_data  (wr_data),
            .pin_sync (pin_sync[p*BYTE_W +: BYTE_W]),
            .view_pin (v_pin),
            .view_out (v_out),
            .view_inv (v_inv),
            .view_dir (v_dir),
            .pin_oe   (pin_oe[p*BYTE_W +: BYTE_W]),
            .pin_out  (pin_out[p*BYTE_W +: BYTE_W])
        );

        always_comb begin
            unique case (acc.kind)
                KIND_PIN: sel_view[p*BYTE_W +: BYTE_W] = v_pin;
                KIND_OUT: sel_view[p*BYTE_W +: BYTE_W] = v_out;
                KIND_INV: sel_view[p*BYTE_W +: BYTE_W] = v_inv;
                KIND_DIR: sel_view[p*BYTE_W +: BYTE_W] = v_dir;
            endcase
        end
    end

    always_comb begin
        rd_next = '0;
        if (acc.hit) begin
            rd_next = sel_view[int'(acc.port)*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (int'(addr) >= 4 * NUM_PORTS)) |=> (rd_data == '0));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R5
    input_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));
endmodule

// File: tb/gpx_core_bench.sv
module gpx_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]  addr_a = '0, wd_a = '0, rdd_a;
    logic        wr_a = 1'b0, rd_a = 1'b0;
    logic [7:0]  pin_a = '0, pout_a, oe_a;
    logic [7:0]  addr_b = '0, wd_b = '0, rdd_b;
    logic        wr_b = 1'b0, rd_b = 1'b0;
    logic [15:0] pin_b = '0, pout_b, oe_b;

    gpx_core #(.NUM_PORTS(1)) u_gpx_core (
        .clk(clk), .rst_n(rst_n), .addr(addr_a), .wr_en(wr_a), .wr_data(wd_a),
        .rd_en(rd_a), .rd_data(rdd_a), .pin_in(pin_a), .pin_out(pout_a), .pin_oe(oe_a)
    );

    gpx_core #(.NUM_PORTS(2)) u_gpx_core_dual (
        .clk(clk), .rst_n(rst_n), .addr(addr_b), .wr_en(wr_b), .wr_data(wd_b),
        .rd_en(rd_b), .rd_data(rdd_b), .pin_in(pin_b), .pin_out(pout_b), .pin_oe(oe_b)
    );

    typedef struct {
        bit         sel;
        logic [7:0] exp;
        string      req;
    } rd_item_t;

    rd_item_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic stb_a = 1'b0, stb_b = 1'b0;

    always @(posedge clk) begin
        stb_a <= rd_a;
        stb_b <= rd_b;
    end

    // scoreboard monitor: compares each registered read one half cycle after its edge
    always @(negedge clk) begin
        if (stb_a || stb_b) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL scoreboard: read with no expected item, actual %h expected none",
                         stb_a ? rdd_a : rdd_b);
            end else begin
                rd_item_t it;
                logic [7:0] act;
                it  = exp_q.pop_front();
                act = it.sel ? rdd_b : rdd_a;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: read actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input bit s, input logic [7:0] a, input logic [7:0] d);
        if (s) begin addr_b = a; wd_b = d; wr_b = 1'b1; end
        else   begin addr_a = a; wd_a = d; wr_a = 1'b1; end
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic rd(input bit s, input logic [7:0] a, input logic [7:0] e, input string req);
        rd_item_t it;
        it.sel = s; it.exp = e; it.req = req;
        exp_q.push_back(it);
        if (s) begin addr_b = a; rd_b = 1'b1; end
        else   begin addr_a = a; rd_a = 1'b1; end
        @(negedge clk);
        rd_a = 1'b0;
        rd_b = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the pins and read register
        check("R1 oe single", {8'h00, oe_a}, 16'h0000);
        check("R1 out single", {8'h00, pout_a}, 16'h0000);
        check("R1 oe dual", oe_b, 16'h0000);
        check("R1 rd_data", {8'h00, rdd_a}, 16'h0000);
        rd(0, 8'd1, 8'hFF, "R1 out reset");
        rd(0, 8'd2, 8'h00, "R1 inv reset");
        rd(0, 8'd3, 8'hFF, "R1 dir reset");
        rd(1, 8'd3, 8'hFF, "R1 R3 dual out p1 reset");
        rd(1, 8'd4, 8'h00, "R1 R3 dual inv p0 reset");
        rd(1, 8'd7, 8'hFF, "R1 R3 dual dir p1 reset");

        // R2 / R6 single-port map and inversion
        pin_a = 8'hA5;
        idle(3);
        rd(0, 8'd0, 8'hA5, "R2 pin sample");
        wr(0, 8'd2, 8'h0F);
        rd(0, 8'd0, 8'hAA, "R6 inverted inputs");
        rd(0, 8'd2, 8'h0F, "R2 inv readback");
        wr(0, 8'd3, 8'hF0);
        check("R4 enables follow direction", {8'h00, oe_a}, 16'h000F);
        check("R5 outputs drive stored ones", {8'h00, pout_a}, 16'h000F);
        rd(0, 8'd0, 8'hA5, "R6 output pins not inverted");
        wr(0, 8'd1, 8'h3C);
        check("R5 input pins masked", {8'h00, pout_a}, 16'h000C);
        rd(0, 8'd1, 8'h3C, "R2 out readback");
        wr(0, 8'd3, 8'h00);
        check("R5 stored bits appear", {8'h00, pout_a}, 16'h003C);
        check("R4 all outputs", {8'h00, oe_a}, 16'h00FF);

        // R7 pin-sample address is read-only
        wr(0, 8'd0, 8'h55);
        check("R7 pins unchanged", {oe_a, pout_a}, 16'hFF3C);
        rd(0, 8'd1, 8'h3C, "R7 out kept");
        rd(0, 8'd2, 8'h0F, "R7 inv kept");
        rd(0, 8'd3, 8'h00, "R7 dir kept");
        rd(0, 8'd0, 8'hA5, "R7 pin sample is pin level");

        // R8 unmapped addresses
        wr(0, 8'd7, 8'hFF);
        wr(0, 8'd5, 8'h00);
        check("R8 write past map ignored", {oe_a, pout_a}, 16'hFF3C);
        rd(0, 8'd1, 8'h3C, "R8 out kept");
        rd(0, 8'd9, 8'h00, "R8 unmapped read");

        // R10 read data holds between strobes
        rd(0, 8'd1, 8'h3C, "R10 setup");
        addr_a = 8'd3;
        idle(3);
        check("R10 hold", {8'h00, rdd_a}, 16'h003C);

        // R9 synchronizer depth
        wr(0, 8'd3, 8'hFF);
        wr(0, 8'd2, 8'h00);
        pin_a = 8'h11;
        @(negedge clk);
        rd(0, 8'd0, 8'hA5, "R9 old level at n+1");
        rd(0, 8'd0, 8'h11, "R9 new level at n+2");

        // R3 dual-port map
        pin_b = 16'hC35A;
        idle(3);
        rd(1, 8'd0, 8'h5A, "R3 pin p0");
        rd(1, 8'd1, 8'hC3, "R3 pin p1");
        wr(1, 8'd5, 8'hFF);
        rd(1, 8'd1, 8'h3C, "R3 R6 inv p1");
        rd(1, 8'd0, 8'h5A, "R3 p0 not inverted");
        wr(1, 8'd6, 8'h00);
        check("R3 R4 dual enables", oe_b, 16'h00FF);
        wr(1, 8'd2, 8'h12);
        wr(1, 8'd3, 8'h34);
        check("R3 R5 dual outputs", pout_b, 16'h0012);
        rd(1, 8'd3, 8'h34, "R3 out p1");
        rd(1, 8'd2, 8'h12, "R3 out p0");
        wr(1, 8'd1, 8'h00);
        wr(1, 8'd9, 8'h00);
        check("R7 R8 dual pins kept", pout_b, 16'h0012);
        rd(1, 8'd7, 8'hFF, "R7 dual dir p1 kept");
        rd(1, 8'd1, 8'h3C, "R7 dual pin p1");
        rd(1, 8'd8, 8'h00, "R8 dual unmapped read");

        idle(3);
        finish_run();
    end
endmodule